// File: doc/BRIEF.md
# Banked Internal Data Store with Bit Addressing

This block is the on-chip data store of a small 8-bit controller. It holds a general RAM of 256 bytes (or 128 bytes in a reduced build) and a separate space of special registers. One request port carries every access: byte reads and writes in direct or indirect mode, register-operand reads and writes, where an operand number 0 to 7 is resolved through a 2-bit bank select, and single-bit reads, sets and clears through an 8-bit bit address.

The upper half of the byte address space leads to two different stores. Indirect accesses there reach the upper RAM. Direct accesses there reach the special registers. Bit addresses below 80H reach a 16-byte window of RAM at 20H to 2FH. Bit addresses from 80H upward reach the special registers whose address is a multiple of eight. The special registers are a generic array with a fixed table of which addresses exist. They carry no peripheral function, apart from the stack-pointer reset value.

Requests use a valid/ready handshake, and read results return on a valid/ready response port. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a response waits and `rsp_ready` is low. A waiting response keeps both its valid flag and its data until it is taken. Write-type requests produce no response.

Top module: `idata_store`

## Requirements
- R1: For byte addresses 00H-7FH, direct (`req_indirect`=0) and indirect (`req_indirect`=1) byte accesses (op 0 read, op 1 write) reach the same RAM byte.
- R2: For byte addresses 80H-FFH, indirect byte accesses reach the upper RAM and direct byte accesses reach the special-register space. A write to one is not seen in the other.
- R3: Register ops (op 2 read, op 3 write) reach RAM byte `bank_sel`*8 + `req_addr[2:0]`.
- R4: Bit ops (op 4 read, op 5 set, op 6 clear) with bit address below 80H reach bit `addr[2:0]` of RAM byte 20H + `addr[6:3]`. A bit read returns the bit in `rsp_data[0]` and zeros in `rsp_data[7:1]`.
- R5: Bit ops with bit address 80H or above reach bit `addr[2:0]` of the special register at `addr` with its low three bits cleared.
- R6: Bit set and clear change only the addressed bit of the byte. All other bits keep their values.
- R7: Special-register addresses outside the implemented set (80,81,82,83,87,88,89,8A,8B,8C,8D,90,98,99,A0,A8,B0,B8,D0,E0,F0 hex) read as 00H. Byte and bit writes to them have no effect.
- R8: After reset, the stack pointer at special address 81H reads 07H and the other implemented special registers read 00H.
- R9: With `RAM_BYTES`=128, indirect byte accesses to 80H-FFH read 00H and their writes are dropped.
- R10: An accepted read-type request (op 0, 2, 4) raises `rsp_valid` with its data after the next rising edge. An accepted write-type request raises no response.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_valid` and `rsp_data` stay unchanged.
- R12: Op 7 is accepted and has no effect on any store and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Operation code (0 rd, 1 wr, 2 reg rd, 3 reg wr, 4 bit rd, 5 bit set, 6 bit clr, 7 none) |
| req_indirect | input | 1 | 1 selects indirect mode for byte ops |
| req_addr | input | 8 | Byte, register or bit address |
| req_wdata | input | 8 | Write data for byte and register writes |
| bank_sel | input | 2 | Register bank for register ops |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Read byte or bit result |

## Verification
The hardest case to reach is a response stalled while the next request is already waiting. The bench holds `rsp_ready` low across a read, keeps a second read valid on the port, and checks that nothing moves until `rsp_ready` returns. It then checks that the queued read completes with its own data. The two stores that share the addresses 80H-FFH are separated by writing different values to the same address in both modes and reading each back. A 128-byte build runs on the same stimulus, so the dropped upper accesses show up at its response port.

// File: rtl/idata_pkg.sv
package idata_pkg;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_RREG = 3'd2,
    OP_WREG = 3'd3,
    OP_BRD  = 3'd4,
    OP_BSET = 3'd5,
    OP_BCLR = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SPC_RAM  = 2'd0,
    SPC_SFR  = 2'd1,
    SPC_NONE = 2'd2
  } space_e;

  typedef struct packed {
    space_e     space;
    logic [7:0] addr;
    logic [2:0] bitn;
    logic       rd;
    logic       wr;
    logic       bit_op;
    logic       bit_val;
  } target_t;

  // Table of implemented special-register addresses
  function automatic logic sfr_present(input logic [7:0] a);
    case (a)
      8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A,
      8'h8B, 8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8,
      8'hB0, 8'hB8, 8'hD0, 8'hE0, 8'hF0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
#(
  parameter logic       HAS_UPPER = 1'b1,
  parameter logic [7:0] BIT_BASE  = 8'h20
) (
  input  op_e        op,
  input  logic       indirect,
  input  logic [7:0] addr,
  input  logic [1:0] bank,
  output target_t    tgt
);

  always_comb begin
    tgt         = '0;
    tgt.space   = SPC_NONE;
    tgt.bitn    = addr[2:0];
    tgt.rd      = (op == OP_RD) || (op == OP_RREG) || (op == OP_BRD);
    tgt.wr      = (op == OP_WR) || (op == OP_WREG) || (op == OP_BSET) || (op == OP_BCLR);
    tgt.bit_op  = (op == OP_BSET) || (op == OP_BCLR);
    tgt.bit_val = (op == OP_BSET);
    case (op)
      OP_RD, OP_WR: begin
        tgt.addr = addr;
        if (!addr[7])      tgt.space = SPC_RAM;
        else if (indirect) tgt.space = HAS_UPPER ? SPC_RAM : SPC_NONE;
        else               tgt.space = SPC_SFR;
      end
      OP_RREG, OP_WREG: begin
        tgt.space = SPC_RAM;
        tgt.addr  = {3'b000, bank, addr[2:0]};
      end
      OP_BRD, OP_BSET, OP_BCLR: begin
        if (!addr[7]) begin
          tgt.space = SPC_RAM;
          tgt.addr  = BIT_BASE + {4'b0000, addr[6:3]};
        end else begin
          tgt.space = SPC_SFR;
          tgt.addr  = {addr[7:3], 3'b000};
        end
      end
      default: tgt.space = SPC_NONE;
    endcase
  end

endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int BYTES = 256,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);

  logic [7:0] mem [BYTES];

  // Combinational read so that bit updates complete in one clock
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

endmodule

// File: rtl/idata_sfr.sv
module idata_sfr
  import idata_pkg::*;
#(
  parameter logic [7:0] SP_ADDR  = 8'h81,
  parameter logic [7:0] SP_RESET = 8'h07,
  localparam int        SLOTS    = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] idx,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic [7:0] slot [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [7:0] ADDR = 8'(128 + i);
    if (sfr_present(ADDR)) begin : g_on
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= (ADDR == SP_ADDR) ? SP_RESET : 8'h00;
        else if (we && idx == 7'(i))   q <= wdata;
      end
      assign slot[i] = q;
    end else begin : g_off
      assign slot[i] = 8'h00;
    end
  end

  assign rdata = slot[idx];

endmodule

// File: rtl/idata_store.sv
module idata_store
  import idata_pkg::*;
#(
  parameter int         RAM_BYTES = 256,
  parameter logic [7:0] SP_ADDR   = 8'h81,
  parameter logic [7:0] SP_RESET  = 8'h07,
  localparam int        RAM_IDX_W = $clog2(RAM_BYTES),
  localparam logic      HAS_UPPER = (RAM_BYTES > 128)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  input  logic       req_indirect,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic [1:0] bank_sel,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data
);

  target_t    tgt;
  logic       accept;
  logic [7:0] ram_rd, sfr_rd, cur_byte, new_byte, bit_mask;
  logic       ram_we, sfr_we;

  idata_decode #(.HAS_UPPER(HAS_UPPER), .BIT_BASE(8'h20)) u_dec (
    .op       (op_e'(req_op)),
    .indirect (req_indirect),
    .addr     (req_addr),
    .bank     (bank_sel),
    .tgt      (tgt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign ram_we = accept && tgt.wr && (tgt.space == SPC_RAM);
  assign sfr_we = accept && tgt.wr && (tgt.space == SPC_SFR);

  idata_ram #(.BYTES(RAM_BYTES)) u_ram (
    .clk   (clk),
    .idx   (tgt.addr[RAM_IDX_W-1:0]),
    .we    (ram_we),
    .wdata (new_byte),
    .rdata (ram_rd)
  );

  idata_sfr #(.SP_ADDR(SP_ADDR), .SP_RESET(SP_RESET)) u_sfr (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (tgt.addr[6:0]),
    .we    (sfr_we),
    .wdata (new_byte),
    .rdata (sfr_rd)
  );

  always_comb begin
    case (tgt.space)
      SPC_RAM: cur_byte = ram_rd;
      SPC_SFR: cur_byte = sfr_rd;
      default: cur_byte = 8'h00;
    endcase
    bit_mask = 8'h01 << tgt.bitn;
    if (!tgt.bit_op)      new_byte = req_wdata;
    else if (tgt.bit_val) new_byte = cur_byte | bit_mask;
    else                  new_byte = cur_byte & ~bit_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (accept && tgt.rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (op_e'(req_op) == OP_BRD) ? {7'b0, cur_byte[tgt.bitn]} : cur_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/idata_store_chk.sv
module idata_store_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data
);

  logic acc, acc_rd;
  assign acc    = req_valid && req_ready;
  assign acc_rd = acc && (req_op == 3'd0 || req_op == 3'd2 || req_op == 3'd4);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);

  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !acc_rd |=> !rsp_valid);

  // R4
  bit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 3'd4 |=> rsp_data[7:1] == 7'd0);

  // R11
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && rsp_ready |=> !rsp_valid);

endmodule

bind idata_store idata_store_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/idata_store_bench.sv
module idata_store_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       req_indirect = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic [1:0] bank_sel = 2'd0;
  logic       rsp_ready = 1'b1;
  logic       req_ready, rsp_valid, req_ready_s, rsp_valid_s;
  logic [7:0] rsp_data, rsp_data_s;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  idata_store u_idata_store (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_indirect(req_indirect), .req_addr(req_addr),
    .req_wdata(req_wdata), .bank_sel(bank_sel), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  idata_store #(.RAM_BYTES(128)) u_idata_store_small (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_s),
    .req_op(req_op), .req_indirect(req_indirect), .req_addr(req_addr),
    .req_wdata(req_wdata), .bank_sel(bank_sel), .rsp_valid(rsp_valid_s),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data_s)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic ind, input logic [7:0] a,
                       input logic [7:0] wd, input logic [1:0] bk);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_indirect = ind;
    req_addr = a; req_wdata = wd; bank_sel = bk;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, input logic ind, input logic [7:0] a,
                    input logic [1:0] bk, output logic [7:0] d, output logic [7:0] ds);
    issue(op, ind, a, 8'h00, bk);
    check("R10 read response valid", {7'b0, rsp_valid}, 8'h01);
    d  = rsp_data;
    ds = rsp_data_s;
  endtask

  task automatic wr(input logic [2:0] op, input logic ind, input logic [7:0] a,
                    input logic [7:0] wd, input logic [1:0] bk);
    issue(op, ind, a, wd, bk);
    check("R10 no response on write", {7'b0, rsp_valid}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d, ds;
    check("R11 ready after reset", {7'b0, req_ready}, 8'h01);
    check("R10 no response after reset", {7'b0, rsp_valid}, 8'h00);
    rd(3'd0, 1'b0, 8'h81, 2'd0, d, ds);
    check("R8 stack pointer reset", d, 8'h07);
    rd(3'd0, 1'b0, 8'h80, 2'd0, d, ds);
    check("R8 other register reset", d, 8'h00);
  endtask

  task automatic t_alias();
    logic [7:0] d, ds;
    wr(3'd1, 1'b0, 8'h45, 8'hA5, 2'd0);
    rd(3'd0, 1'b1, 8'h45, 2'd0, d, ds);
    check("R1 direct write indirect read", d, 8'hA5);
    wr(3'd1, 1'b1, 8'h10, 8'h3C, 2'd0);
    rd(3'd0, 1'b0, 8'h10, 2'd0, d, ds);
    check("R1 indirect write direct read", d, 8'h3C);
  endtask

  task automatic t_split();
    logic [7:0] d, ds;
    wr(3'd1, 1'b1, 8'h90, 8'h77, 2'd0);
    wr(3'd1, 1'b0, 8'h90, 8'h5A, 2'd0);
    rd(3'd0, 1'b1, 8'h90, 2'd0, d, ds);
    check("R2 upper RAM keeps value", d, 8'h77);
    check("R9 small build upper read zero", ds, 8'h00);
    rd(3'd0, 1'b0, 8'h90, 2'd0, d, ds);
    check("R2 special register keeps value", d, 8'h5A);
    check("R2 small build special register", ds, 8'h5A);
  endtask

  task automatic t_banks();
    logic [7:0] d, ds;
    wr(3'd3, 1'b0, 8'h05, 8'hC3, 2'd2);
    rd(3'd0, 1'b0, 8'h15, 2'd0, d, ds);
    check("R3 bank 2 reg 5 at 15H", d, 8'hC3);
    wr(3'd1, 1'b0, 8'h0B, 8'h99, 2'd0);
    rd(3'd2, 1'b0, 8'h03, 2'd1, d, ds);
    check("R3 bank 1 reg 3 from 0BH", d, 8'h99);
    wr(3'd1, 1'b0, 8'h1F, 8'h6E, 2'd0);
    rd(3'd2, 1'b0, 8'h07, 2'd3, d, ds);
    check("R3 bank 3 reg 7 from 1FH", d, 8'h6E);
  endtask

  task automatic t_bit_ram();
    logic [7:0] d, ds;
    wr(3'd1, 1'b0, 8'h2A, 8'h00, 2'd0);
    wr(3'd5, 1'b0, 8'h53, 8'h00, 2'd0);
    rd(3'd0, 1'b0, 8'h2A, 2'd0, d, ds);
    check("R4 set bit 53H lands in 2AH bit 3", d, 8'h08);
    rd(3'd4, 1'b0, 8'h53, 2'd0, d, ds);
    check("R4 bit read set bit", d, 8'h01);
    rd(3'd4, 1'b0, 8'h52, 2'd0, d, ds);
    check("R4 bit read clear bit", d, 8'h00);
    wr(3'd1, 1'b0, 8'h24, 8'hF0, 2'd0);
    wr(3'd6, 1'b0, 8'h25, 8'h00, 2'd0);
    rd(3'd0, 1'b0, 8'h24, 2'd0, d, ds);
    check("R6 clear bit 5 keeps others", d, 8'hD0);
    wr(3'd5, 1'b0, 8'h20, 8'h00, 2'd0);
    rd(3'd0, 1'b0, 8'h24, 2'd0, d, ds);
    check("R6 set bit 0 keeps others", d, 8'hD1);
  endtask

  task automatic t_bit_sfr();
    logic [7:0] d, ds;
    wr(3'd1, 1'b0, 8'hE0, 8'h00, 2'd0);
    wr(3'd5, 1'b0, 8'hE7, 8'h00, 2'd0);
    rd(3'd0, 1'b0, 8'hE0, 2'd0, d, ds);
    check("R5 set bit E7H in register E0H", d, 8'h80);
    rd(3'd4, 1'b0, 8'hE7, 2'd0, d, ds);
    check("R5 bit read E7H", d, 8'h01);
    wr(3'd1, 1'b0, 8'hD0, 8'hFF, 2'd0);
    wr(3'd6, 1'b0, 8'hD3, 8'h00, 2'd0);
    rd(3'd0, 1'b0, 8'hD0, 2'd0, d, ds);
    check("R5 R6 clear bit D3H", d, 8'hF7);
  endtask

  task automatic t_absent();
    logic [7:0] d, ds;
    wr(3'd1, 1'b0, 8'hC0, 8'h12, 2'd0);
    rd(3'd0, 1'b0, 8'hC0, 2'd0, d, ds);
    check("R7 absent register write ignored", d, 8'h00);
    wr(3'd5, 1'b0, 8'hC3, 8'h00, 2'd0);
    rd(3'd4, 1'b0, 8'hC3, 2'd0, d, ds);
    check("R7 absent register bit set ignored", d, 8'h00);
    wr(3'd1, 1'b0, 8'h84, 8'hFF, 2'd0);
    rd(3'd0, 1'b0, 8'h84, 2'd0, d, ds);
    check("R7 absent 84H reads zero", d, 8'h00);
  endtask

  task automatic t_small_drop();
    logic [7:0] d, ds;
    wr(3'd1, 1'b1, 8'hF3, 8'h4D, 2'd0);
    rd(3'd0, 1'b1, 8'hF3, 2'd0, d, ds);
    check("R9 full build upper write kept", d, 8'h4D);
    check("R9 small build upper write dropped", ds, 8'h00);
    rd(3'd0, 1'b1, 8'h45, 2'd0, d, ds);
    check("R9 small build lower RAM intact", ds, 8'hA5);
  endtask

  task automatic t_nop();
    logic [7:0] d, ds;
    wr(3'd7, 1'b0, 8'h45, 8'h00, 2'd0);
    rd(3'd0, 1'b0, 8'h45, 2'd0, d, ds);
    check("R12 op 7 leaves byte", d, 8'hA5);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 3'd0; req_indirect = 1'b0; req_addr = 8'h45;
    @(posedge clk);
    @(negedge clk);
    check("R11 stalled response valid", {7'b0, rsp_valid}, 8'h01);
    check("R11 stalled response data", rsp_data, 8'hA5);
    req_addr = 8'h10;
    check("R11 ready low while stalled", {7'b0, req_ready}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R11 data held during stall", rsp_data, 8'hA5);
    check("R11 valid held during stall", {7'b0, rsp_valid}, 8'h01);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 queued read completes", rsp_data, 8'h3C);
    @(posedge clk);
    @(negedge clk);
    check("R10 response drained", {7'b0, rsp_valid}, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alias();
    t_split();
    t_banks();
    t_bit_ram();
    t_bit_sfr();
    t_absent();
    t_small_drop();
    t_nop();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule